// File: doc/BRIEF.md
# Toggle-Coded Busy and Stop Link

This block moves a busy request over a link that is AC-coupled and so cannot hold a static level. Each front-end transmitter converts its local busy level into line activity: the line inverts at a fixed rate while busy is high and stays frozen while busy is low. At the central controller, one receiver per link brings the line into the local clock domain and watches it for any change. A change asserts a recovered busy level. That level is held until the line has been quiet for longer than one toggle period.

The controller combines the recovered busy levels of all links into a single stop-acquisition request. It sends that request back toward the detector with the same toggle coding. A matching receiver on the front-end side recovers the stop level from that line. In a system, each link's `fe_line_o` reaches `hub_line_i` through the cable, and `stop_line_o` reaches `fe_stop_line_i` the same way. No data is encoded on either path: only activity is carried.

Top module: `busy_toggle_link`

## Requirements
- R1: While `fe_busy_i[i]` is sampled high on consecutive rising edges, `fe_line_o[i]` inverts on every TOGGLE_DIV-th such edge, with the first inversion on the TOGGLE_DIV-th edge.
- R2: An edge that samples `fe_busy_i[i]` low leaves `fe_line_o[i]` unchanged and restarts the toggle count. A busy pulse shorter than TOGGLE_DIV clocks therefore produces no inversion.
- R3: Any change of `hub_line_i[i]` makes `hub_busy_o[i]` high from the (SYNC_STAGES+1)-th rising edge after the edge that first samples the change. The same holds for `fe_stop_line_i` and `fe_stop_o`.
- R4: A recovered busy level returns low on the HOLD_CYCLES-th edge after it was last set or refreshed by a change. HOLD_CYCLES exceeds TOGGLE_DIV, so a steadily toggling line keeps it high.
- R5: `stop_req_o` is high exactly when at least one bit of `hub_busy_o` is high, in the same cycle.
- R6: `stop_line_o` encodes `stop_req_o` with the toggle rule of R1 and R2. Looped back to `fe_stop_line_i`, it yields `fe_stop_o` by the rule of R3 and R4.
- R7: While and right after reset, all recovered levels, `stop_req_o` and every transmit line are low.
- R8: Activity on one link changes only that link's bit of `hub_busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_busy_i | input | NUM_LINKS | Local busy level of each front end |
| fe_line_o | output | NUM_LINKS | Toggle-coded busy line sent by each front end |
| hub_line_i | input | NUM_LINKS | Toggle-coded busy lines arriving at the controller |
| hub_busy_o | output | NUM_LINKS | Busy level recovered per link |
| stop_req_o | output | 1 | OR of all recovered busy levels |
| stop_line_o | output | 1 | Toggle-coded stop-acquisition line sent to the detector |
| fe_stop_line_i | input | 1 | Stop line arriving at a front end |
| fe_stop_o | output | 1 | Stop-acquisition level recovered at the front end |

## Verification
A toggle counter that skips or repeats a count moves the instant of a line inversion, and this shows on `fe_line_o` within TOGGLE_DIV clocks. A quiet counter that runs off by one moves the fall of `hub_busy_o` by one cycle. A wrong synchroniser depth moves its rise. Both appear on every busy pulse, and the bench predicts each of these edges arithmetically from the pulse length. A stuck edge-detect register shows as a level that never rises or never falls. A stale stop-path count shows at `stop_line_o` and `fe_stop_o` one round trip later.

// File: rtl/busy_link_pkg.sv
package busy_link_pkg;
   // width of a counter that must reach n-1
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/blink_toggle_tx.sv
module blink_toggle_tx #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic line_o
);
   generate
      if (DIV == 1) begin : g_every
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       line_o <= 1'b0;
            else if (level_i) line_o <= ~line_o;
         end
      end else begin : g_div
         localparam int unsigned CW = busy_link_pkg::cnt_w(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
               line_o  <= 1'b0;
            end else if (!level_i) begin
               phase_q <= '0;
            end else if (phase_q == LAST) begin
               phase_q <= '0;
               line_o  <= ~line_o;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/blink_activity_rx.sv
module blink_activity_rx #(
   parameter int unsigned SYNC = 2,
   parameter int unsigned HOLD = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o
);
   localparam int unsigned HW = busy_link_pkg::cnt_w(HOLD);
   localparam logic [HW-1:0] HLAST = HW'(HOLD - 1);

   logic [SYNC-1:0] sync_q;
   logic            last_q;
   logic            act;
   logic [HW-1:0]   quiet_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC-2:0], line_i};
         last_q <= sync_q[SYNC-1];
      end
   end

   assign act = sync_q[SYNC-1] ^ last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o <= 1'b0;
         quiet_q <= '0;
      end else if (act) begin
         level_o <= 1'b1;
         quiet_q <= '0;
      end else if (level_o) begin
         if (quiet_q == HLAST) begin
            level_o <= 1'b0;
            quiet_q <= '0;
         end else begin
            quiet_q <= quiet_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/busy_toggle_link.sv
module busy_toggle_link #(
   parameter int unsigned NUM_LINKS   = 4,
   parameter int unsigned TOGGLE_DIV  = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYCLES = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINKS-1:0] fe_busy_i,
   output logic [NUM_LINKS-1:0] fe_line_o,
   input  logic [NUM_LINKS-1:0] hub_line_i,
   output logic [NUM_LINKS-1:0] hub_busy_o,
   output logic                 stop_req_o,
   output logic                 stop_line_o,
   input  logic                 fe_stop_line_i,
   output logic                 fe_stop_o
);
   generate
      if (NUM_LINKS < 1 || NUM_LINKS > 8) begin : g_bad_links
         $error("NUM_LINKS must be 1..8");
      end
      if (TOGGLE_DIV < 1) begin : g_bad_div
         $error("TOGGLE_DIV must be at least 1");
      end
      if (HOLD_CYCLES <= TOGGLE_DIV) begin : g_bad_hold
         $error("HOLD_CYCLES must exceed TOGGLE_DIV");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 2..4");
      end

      for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
         blink_toggle_tx #(.DIV(TOGGLE_DIV)) u_tx (
            .clk(clk), .rst_n(rst_n), .level_i(fe_busy_i[i]), .line_o(fe_line_o[i])
         );
         blink_activity_rx #(.SYNC(SYNC_STAGES), .HOLD(HOLD_CYCLES)) u_rx (
            .clk(clk), .rst_n(rst_n), .line_i(hub_line_i[i]), .level_o(hub_busy_o[i])
         );
      end
   endgenerate

   assign stop_req_o = |hub_busy_o;

   blink_toggle_tx #(.DIV(TOGGLE_DIV)) u_stop_tx (
      .clk(clk), .rst_n(rst_n), .level_i(stop_req_o), .line_o(stop_line_o)
   );

   blink_activity_rx #(.SYNC(SYNC_STAGES), .HOLD(HOLD_CYCLES)) u_stop_rx (
      .clk(clk), .rst_n(rst_n), .line_i(fe_stop_line_i), .level_o(fe_stop_o)
   );
endmodule

// File: rtl/busy_link_chk.sv
module busy_link_chk #(
   parameter int unsigned NUM_LINKS   = 4,
   parameter int unsigned TOGGLE_DIV  = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINKS-1:0] fe_busy_i,
   input logic [NUM_LINKS-1:0] fe_line_o,
   input logic [NUM_LINKS-1:0] hub_line_i,
   input logic [NUM_LINKS-1:0] hub_busy_o,
   input logic                 stop_req_o,
   input logic                 stop_line_o,
   input logic                 fe_stop_line_i,
   input logic                 fe_stop_o
);
   generate
      for (genvar i = 0; i < NUM_LINKS; i++) begin : g_chk
         p_idle_static_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !fe_busy_i[i] |=> $stable(fe_line_o[i]));

         p_edge_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (hub_line_i[i] != $past(hub_line_i[i])) |-> ##(SYNC_STAGES+1) hub_busy_o[i]);

         if (TOGGLE_DIV > 1) begin : g_spacing
            p_toggle_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
               (fe_line_o[i] != $past(fe_line_o[i])) |=> $stable(fe_line_o[i]));
         end
      end
   endgenerate

   p_stop_idle_static_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_req_o |=> $stable(stop_line_o));

   p_stop_edge_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_stop_line_i != $past(fe_stop_line_i)) |-> ##(SYNC_STAGES+1) fe_stop_o);
endmodule

bind busy_toggle_link busy_link_chk #(
   .NUM_LINKS(NUM_LINKS), .TOGGLE_DIV(TOGGLE_DIV), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fe_busy_i(fe_busy_i), .fe_line_o(fe_line_o),
   .hub_line_i(hub_line_i), .hub_busy_o(hub_busy_o), .stop_req_o(stop_req_o),
   .stop_line_o(stop_line_o), .fe_stop_line_i(fe_stop_line_i), .fe_stop_o(fe_stop_o)
);

// File: tb/tb_busy_toggle_link.sv
module tb_busy_toggle_link;
   localparam int CLK_PERIOD = 10;
   localparam int N = 4;
   localparam int K = 4;
   localparam int S = 2;
   localparam int M = 10;
   localparam int L = K + S + 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] fe_busy = '0;
   logic [N-1:0] inj = '0;
   logic [N-1:0] fe_line, hub_line, hub_busy;
   logic         stop_req, stop_line, fe_stop;
   int           errors = 0;
   int           checks = 0;

   assign hub_line = fe_line ^ inj;

   busy_toggle_link #(.NUM_LINKS(N), .TOGGLE_DIV(K), .SYNC_STAGES(S), .HOLD_CYCLES(M)) dut (
      .clk(clk), .rst_n(rst_n), .fe_busy_i(fe_busy), .fe_line_o(fe_line),
      .hub_line_i(hub_line), .hub_busy_o(hub_busy), .stop_req_o(stop_req),
      .stop_line_o(stop_line), .fe_stop_line_i(stop_line), .fe_stop_o(fe_stop)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   // busy held on the links in mask for hi_len sampled edges
   task automatic run_busy(input logic [N-1:0] mask, input int hi_len);
      int c, b, last, t_end, m, tc;
      bit rises;
      logic [N-1:0] l0, e;
      logic s0, hub_on, stop_on;
      c = (hi_len / K) * K;
      rises = (c >= K);
      b = c + S + M;
      last = L + ((b - L + 1) / K) * K;
      t_end = rises ? last + S + M + 3 : L + 3;
      l0 = fe_line;
      s0 = stop_line;
      fe_busy = mask;
      for (int n = 1; n <= t_end; n++) begin
         @(posedge clk); #1;
         m = (n < hi_len) ? n : hi_len;
         e = l0 ^ ((((m / K) % 2) == 1) ? mask : '0);
         chk((n <= hi_len) ? "R1" : "R2", fe_line, e);
         hub_on = rises && n >= L && n <= b;
         chk(hub_on ? "R3" : "R4", hub_busy & mask, hub_on ? mask : '0);
         chk("R8", hub_busy & ~mask, '0);
         chk("R5", {{(N-1){1'b0}}, stop_req}, {{(N-1){1'b0}}, hub_on});
         tc = (rises && n > L) ? ((((n < b + 1) ? n : b + 1) - L) / K) : 0;
         chk("R6", {{(N-1){1'b0}}, stop_line}, {{(N-1){1'b0}}, s0 ^ tc[0]});
         stop_on = rises && n >= 2 * L && n <= last + S + M;
         chk("R6", {{(N-1){1'b0}}, fe_stop}, {{(N-1){1'b0}}, stop_on});
         if (n == hi_len) fe_busy = '0;
      end
      idle(4);
   endtask

   // a single forced change on one receive line
   task automatic inject(input int link);
      logic [N-1:0] bit1, e;
      bit1 = '0;
      bit1[link] = 1'b1;
      inj = inj ^ bit1;
      for (int n = 1; n <= S + M + 3; n++) begin
         @(posedge clk); #1;
         e = (n >= S + 1 && n <= S + M) ? bit1 : '0;
         chk((e != 0) ? "R3" : "R4", hub_busy, e);
      end
      idle(2 * (L + M + K) + 8);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R7", hub_busy, '0);
      chk("R7", fe_line, '0);
      chk("R7", {{(N-1){1'b0}}, stop_req | stop_line | fe_stop}, '0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R7", hub_busy, '0);
      chk("R7", fe_line, '0);
      chk("R7", {{(N-1){1'b0}}, stop_req | stop_line | fe_stop}, '0);

      for (int h = 1; h <= 3 * K + 1; h++) run_busy(4'b0001, h);
      for (int k = 1; k < N; k++) begin
         run_busy(N'(1) << k, K);
         run_busy(N'(1) << k, 2 * K + 1);
      end
      run_busy(4'b0101, 9);
      run_busy(4'b1111, 6);
      run_busy(4'b0010, K - 1);
      for (int k = 0; k < N; k++) inject(k);

      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end
endmodule